// File: doc/BRIEF.md
# Four-Lane Byte Blend Unit

This block blends one 32-bit pixel word per operation, split into four independent 8-bit lanes. Each lane scales a foreground byte by its own 8-bit alpha fraction and adds a second product supplied by the host. That second product is the background colour already weighted by one minus alpha. Computing only one of the two multiplications inside each lane keeps the datapath small, and the host, which already holds the background term, supplies the rest.

A per-byte enable mask chooses which lanes write a new result. A lane whose enable is low returns the incoming destination byte unchanged, so a partial-word update can be merged into the existing pixel. Inputs arrive on a valid/data interface with no back-pressure. Results leave with a fixed two-cycle latency, and the enable mask travels with them. When no operation is in flight, the outputs keep their last values.

Top module: `blend_quad`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid is 0, out_pix is 0 and out_be is 0.
- R2: out_valid rises exactly two rising clock edges after the edge that samples in_valid high, and is low otherwise.
- R3: Lane i uses bits [8i+7:8i] of in_fg, in_alpha, in_bgprod, in_dst and out_pix, and bit i of in_be and out_be. The lanes do not interact.
- R4: The scaled foreground of an enabled lane equals round(alpha × fg / 255), computed as (p + 128 + ((p + 128) >> 8)) >> 8 with p = alpha × fg.
- R5: The byte result of an enabled lane is the scaled foreground plus the lane's in_bgprod byte. A sum above 255 gives 255.
- R6: With alpha 0xFF an enabled lane yields fg + bgprod (saturated). With alpha 0x00 it yields the bgprod byte.
- R7: A lane whose in_be bit is 0 outputs its in_dst byte unchanged, whatever its other inputs are.
- R8: out_be equals the in_be value sampled with the same operation.
- R9: When no result is delivered (out_valid low), out_pix and out_be hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| in_fg | input | 32 | Foreground bytes, one per lane |
| in_alpha | input | 32 | Alpha fraction per lane, 0xFF means 1.0 |
| in_bgprod | input | 32 | Host-supplied weighted background product per lane |
| in_dst | input | 32 | Existing destination pixel bytes |
| in_be | input | 4 | Lane write enables |
| out_valid | output | 1 | Result present on out_pix |
| out_pix | output | 32 | Blended pixel word |
| out_be | output | 4 | Enable mask that went with the result |

## Verification
Every result is due on the second rising edge after the edge that samples its operation. The driver stamps each expected item with that edge number, and the monitor samples on the falling edge and compares the stamp with the current edge count, so an early, late or missing result is reported. On falling edges where out_valid is low, the monitor checks that out_pix and out_be still hold the last delivered values. The bench sends stimulus with random gaps and also back-to-back.

// File: rtl/blend_pkg.sv
package blend_pkg;

    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;
    localparam int PROD_W = 2 * BYTE_W;
    localparam int LAT    = 2;

    typedef logic [BYTE_W-1:0] byte_t;

    // Stage-1 state of one lane
    typedef struct packed {
        byte_t prod;
        byte_t bgp;
        byte_t dst;
        logic  en;
    } lane_s1_t;

    // alpha * x / 255, rounded to nearest, without a divider
    function automatic byte_t scale_frac(byte_t a, byte_t x);
        logic [PROD_W:0] t;
        t = {{(BYTE_W+1){1'b0}}, a} * {{(BYTE_W+1){1'b0}}, x};
        t = t + (PROD_W+1)'(1 << (BYTE_W-1));
        t = t + (t >> BYTE_W);
        return t[BYTE_W +: BYTE_W];
    endfunction

    // Saturating byte add
    function automatic byte_t sat_add(byte_t p, byte_t q);
        logic [BYTE_W:0] s;
        s = {1'b0, p} + {1'b0, q};
        return s[BYTE_W] ? {BYTE_W{1'b1}} : s[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/blend_ctrl_pipe.sv
module blend_ctrl_pipe
    import blend_pkg::*;
#(
    parameter int NL = LANES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [NL-1:0] in_be,
    output logic          s1_valid,
    output logic          out_valid,
    output logic [NL-1:0] out_be
);

    logic [LAT-1:0]         v_q;
    logic [LAT-1:0][NL-1:0] be_q;

    generate
        for (genvar s = 0; s < LAT; s++) begin : g_stage
            logic          v_prev;
            logic [NL-1:0] be_prev;
            if (s == 0) begin : g_first
                assign v_prev  = in_valid;
                assign be_prev = in_be;
            end else begin : g_next
                assign v_prev  = v_q[s-1];
                assign be_prev = be_q[s-1];
            end
            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q[s]  <= 1'b0;
                    be_q[s] <= '0;
                end else begin
                    v_q[s] <= v_prev;
                    if (v_prev) be_q[s] <= be_prev;
                end
            end
        end
    endgenerate

    assign s1_valid  = v_q[0];
    assign out_valid = v_q[LAT-1];
    assign out_be    = be_q[LAT-1];

    // R9: the mask moves only when a result is delivered
    assert_be_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_be) || $past(rst));

endmodule

// File: rtl/blend_lane.sv
module blend_lane
    import blend_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  s1_valid,
    input  logic  en,
    input  byte_t alpha,
    input  byte_t fg,
    input  byte_t bgp,
    input  byte_t dst,
    output byte_t res
);

    lane_s1_t s1_q;
    byte_t    res_q;

    // Stage 1: scaled foreground plus the operands carried forward
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else if (in_valid) begin
            s1_q.prod <= scale_frac(alpha, fg);
            s1_q.bgp  <= bgp;
            s1_q.dst  <= dst;
            s1_q.en   <= en;
        end
    end

    // Stage 2: saturating add, or pass the destination byte through
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (s1_valid) begin
            res_q <= s1_q.en ? sat_add(s1_q.prod, s1_q.bgp) : s1_q.dst;
        end
    end

    assign res = res_q;

    // R5: an enabled result never falls below the host product
    assert_sat_floor_R5: assert property (@(posedge clk) disable iff (rst)
        s1_valid && s1_q.en |=> res >= $past(s1_q.bgp));

    // R7: a disabled lane returns its destination byte
    assert_passthru_R7: assert property (@(posedge clk) disable iff (rst)
        s1_valid && !s1_q.en |=> res == $past(s1_q.dst));

    // R9: no delivery, no change
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> $stable(res));

endmodule

// File: rtl/blend_quad.sv
module blend_quad
    import blend_pkg::*;
#(
    parameter int NL = LANES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [NL*BYTE_W-1:0] in_fg,
    input  logic [NL*BYTE_W-1:0] in_alpha,
    input  logic [NL*BYTE_W-1:0] in_bgprod,
    input  logic [NL*BYTE_W-1:0] in_dst,
    input  logic [NL-1:0]      in_be,
    output logic               out_valid,
    output logic [NL*BYTE_W-1:0] out_pix,
    output logic [NL-1:0]      out_be
);

    logic s1_valid;

    blend_ctrl_pipe #(.NL(NL)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_be    (in_be),
        .s1_valid (s1_valid),
        .out_valid(out_valid),
        .out_be   (out_be)
    );

    generate
        for (genvar i = 0; i < NL; i++) begin : g_lane
            byte_t res_i;
            blend_lane u_lane (
                .clk     (clk),
                .rst     (rst),
                .in_valid(in_valid),
                .s1_valid(s1_valid),
                .en      (in_be[i]),
                .alpha   (in_alpha[i*BYTE_W +: BYTE_W]),
                .fg      (in_fg[i*BYTE_W +: BYTE_W]),
                .bgp     (in_bgprod[i*BYTE_W +: BYTE_W]),
                .dst     (in_dst[i*BYTE_W +: BYTE_W]),
                .res     (res_i)
            );
            assign out_pix[i*BYTE_W +: BYTE_W] = res_i;
        end
    endgenerate

    // Cycles since reset, saturating, gates the two-deep look-back
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst) age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R2: fixed two-edge latency of the valid flag
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        age_q >= 2'd2 |-> out_valid == $past(in_valid, 2));

    // R8: the mask arrives with its operation
    assert_be_align_R8: assert property (@(posedge clk) disable iff (rst)
        age_q >= 2'd2 && out_valid |-> out_be == $past(in_be, 2));

    // R1: quiet right after reset
    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> !out_valid && out_pix == '0 && out_be == '0);

endmodule

// File: tb/blend_quad_bench.sv
module blend_quad_bench;
    import blend_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_fg = '0, in_alpha = '0, in_bgprod = '0, in_dst = '0;
    logic [3:0]  in_be = '0;
    logic        out_valid;
    logic [31:0] out_pix;
    logic [3:0]  out_be;

    always #2.5 clk = ~clk;   // 200 MHz

    blend_quad u_blend_quad (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_fg(in_fg), .in_alpha(in_alpha), .in_bgprod(in_bgprod),
        .in_dst(in_dst), .in_be(in_be),
        .out_valid(out_valid), .out_pix(out_pix), .out_be(out_be)
    );

    typedef struct {
        logic [31:0] pix;
        logic [3:0]  be;
        int          due;
    } exp_t;

    exp_t        sb[$];
    int          edges = 0;
    int          checks = 0;
    int          fails = 0;
    logic [31:0] last_pix = '0;
    logic [3:0]  last_be = '0;
    bit          mon_on = 1'b0;
    bit          done = 1'b0;

    always @(posedge clk) edges <= edges + 1;

    // Independent reference: exact rounding of a*x/255 (odd divisor, no ties)
    function automatic logic [7:0] ref_lane(logic [7:0] a, logic [7:0] x,
                                            logic [7:0] b);
        int q;
        q = (2 * int'(a) * int'(x) + 255) / 510 + int'(b);
        return (q > 255) ? 8'hFF : 8'(q);
    endfunction

    task automatic check(bit ok, string req, string what,
                         logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: one operation per call, R3 lane layout in the model
    task automatic drive(logic [31:0] fg, logic [31:0] al, logic [31:0] bg,
                         logic [31:0] dst, logic [3:0] be);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_fg = fg; in_alpha = al; in_bgprod = bg;
        in_dst = dst; in_be = be;
        for (int i = 0; i < 4; i++) begin
            e.pix[i*8 +: 8] = be[i] ? ref_lane(al[i*8 +: 8], fg[i*8 +: 8],
                                               bg[i*8 +: 8])
                                    : dst[i*8 +: 8];   // R7
        end
        e.be  = be;
        e.due = edges + 2;   // R2
        sb.push_back(e);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_fg = $urandom; in_alpha = $urandom; in_bgprod = $urandom;
            in_dst = $urandom; in_be = 4'($urandom);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2", "unexpected result", 32'(out_valid), 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(edges == e.due, "R2", "result edge",
                          32'(edges), 32'(e.due));
                    check(out_pix == e.pix, "R4/R5/R7", "pixel", out_pix, e.pix);
                    check(out_be == e.be, "R8", "mask", 32'(out_be), 32'(e.be));
                end
                last_pix = out_pix;
                last_be  = out_be;
            end else begin
                check(out_pix == last_pix && out_be == last_be, "R9", "hold",
                      out_pix, last_pix);
                if (sb.size() != 0 && edges > sb[0].due)
                    check(1'b0, "R2", "missing result", 32'(edges), 32'(sb[0].due));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0 && out_pix == '0 && out_be == '0, "R1",
              "reset state", out_pix, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_pix == '0, "R1", "after reset",
              out_pix, 32'd0);
        mon_on = 1'b1;

        // R6: full alpha passes fg; zero alpha leaves bgprod
        drive(32'h10_80_FF_01, 32'hFF_FF_FF_FF, 32'h00_05_00_02, 32'h0, 4'hF);
        drive(32'hFF_FF_FF_FF, 32'h00_00_00_00, 32'h11_22_33_44, 32'h0, 4'hF);
        // R5: saturation
        drive(32'hC8_FF_80_F0, 32'hFF_FF_FF_80, 32'h64_01_80_F0, 32'h0, 4'hF);
        // R7: disabled lanes keep dst, others blend
        drive(32'hAA_BB_CC_DD, 32'h40_80_C0_FF, 32'h01_02_03_04,
              32'h5A_A5_3C_C3, 4'b0101);
        drive(32'hFF_FF_FF_FF, 32'hFF_FF_FF_FF, 32'hFF_FF_FF_FF,
              32'h12_34_56_78, 4'b0000);
        idle(3);
        // R3/R4: distinct alpha per lane, rounding points
        drive(32'h80_80_80_80, 32'h01_7F_80_FE, 32'h0, 32'h0, 4'hF);
        drive(32'h01_FF_03_7F, 32'h80_01_55_81, 32'h0, 32'h0, 4'hF);
        idle(2);

        // Random traffic, gaps and back-to-back
        for (int n = 0; n < 400; n++) begin
            drive($urandom, $urandom, $urandom, $urandom, 4'($urandom));
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        idle(6);
        check(sb.size() == 0, "R2", "drained", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule